// File: doc/BRIEF.md
# Interleaved Two-Port Halfword-Bank Data Memory

This block is an on-chip data store that two load/store ports, A and B, can use in the same clock cycle. It is built from several single-ported banks, each 16 bits wide. Consecutive halfwords are placed in consecutive banks, so accesses that sit next to each other in memory usually land in different banks and can run at the same time. Each port can make byte, halfword or word accesses. A word access covers two neighbouring banks.

On every cycle the block works out which banks each request needs. If the two requests need disjoint banks, both are accepted in that cycle. If they need a common bank, port A goes first and port B waits one extra cycle. The arbiter is a two-state machine:

- ARB_BOTH is the reset and idle state. Port A is always accepted here, and port B is accepted unless it clashes with A.
- A clash causes the transition ARB_BOTH → ARB_DEFER_B.
- ARB_DEFER_B serves only the held request on port B. It always returns to ARB_BOTH on the next cycle (transition ARB_DEFER_B → ARB_BOTH).
- When there is no clash, the machine takes the transition ARB_BOTH → ARB_BOTH.

Misaligned and reserved-size requests are accepted but never touch a bank. They report an error in their response instead.

Top module: `ilv_dual_mem`

## Requirements
- R1: The bank index is byte address bits [2:1], and the row inside a bank is bits [8:3] (defaults). Byte addresses 0–1 map to bank 0, 2–3 to bank 1, 4–5 to bank 2 and 6–7 to bank 3, and the pattern repeats every 8 bytes. A word at byte address w occupies bank w[2:1] (low half) and the next bank (high half). Data is little-endian.
- R2: After reset, neither port shows a response (x_rvalid low) and the arbiter is in ARB_BOTH.
- R3: When the two requests use disjoint banks, both x_ready outputs are high in the same cycle.
- R4: When both requests need a common bank, A is accepted and b_ready is low for that cycle. B, held unchanged, is accepted in the next cycle. B observes any write that A made in the previous cycle.
- R5: In the cycle where the deferred B is served, a request on port A is not accepted (a_ready low). A is accepted in the following cycle.
- R6: x_rvalid is high exactly one cycle after each accepted request. x_rdata then carries the read value, zero-extended for byte and halfword reads, and is 0 for writes. Both ports have the same one-cycle latency.
- R7: The size code is 0 for byte, 1 for halfword, 2 for word and 3 for reserved. A word with address bits [1:0] non-zero, a halfword with bit 0 set, or size 3 is accepted and answered with x_err high and x_rdata 0. Such a request modifies no memory and never clashes with the other port.
- R8: A byte write changes only the addressed byte. A halfword write changes only its two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_size | input | 2 | Port A access size code |
| a_addr | input | 9 | Port A byte address |
| a_wdata | input | 32 | Port A write data, right-aligned |
| a_ready | output | 1 | Port A request accepted this cycle |
| a_rvalid | output | 1 | Port A response valid |
| a_err | output | 1 | Port A response is an alignment/size error |
| a_rdata | output | 32 | Port A read data |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_size | input | 2 | Port B access size code |
| b_addr | input | 9 | Port B byte address |
| b_wdata | input | 32 | Port B write data, right-aligned |
| b_ready | output | 1 | Port B request accepted this cycle |
| b_rvalid | output | 1 | Port B response valid |
| b_err | output | 1 | Port B response is an alignment/size error |
| b_rdata | output | 32 | Port B read data |

## Verification
Two functions can fall in the same cycle: a write from one port and an access from the other port that needs the same bank. The bench provokes this with random pairs drawn mostly from a small address window and with directed word-against-halfword clashes. It judges the result with a reference byte array that applies A before B, so a deferred B read must return A's freshly written data. It also checks A being refused while the deferred B is served, and malformed requests sharing a cycle with a valid one on the same banks.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ARB_BOTH    = 1'b0,
        ARB_DEFER_B = 1'b1
    } arb_state_e;
endpackage

// File: rtl/ilv_decode.sv
module ilv_decode
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 9,
    parameter int IDX_W     = $clog2(NUM_BANKS),
    parameter int ROW_W     = ADDR_W - IDX_W - 1
) (
    input  logic [1:0]           size,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic                 bad,
    output logic [NUM_BANKS-1:0] mask,
    output logic [IDX_W-1:0]     idx,
    output logic [ROW_W-1:0]     row,
    output logic                 lane,
    output logic [1:0]           lane_be,
    output logic [15:0]          wd_even,
    output logic [15:0]          wd_odd
);
    acc_size_e sz;

    assign sz   = acc_size_e'(size);
    assign idx  = addr[IDX_W:1];
    assign row  = addr[ADDR_W-1:IDX_W+1];
    assign lane = addr[0];

    always_comb begin
        bad     = 1'b0;
        mask    = '0;
        lane_be = 2'b11;
        wd_even = wdata[15:0];
        wd_odd  = wdata[15:0];
        unique case (sz)
            SZ_BYTE: begin
                mask[idx] = 1'b1;
                lane_be   = addr[0] ? 2'b10 : 2'b01;
                wd_even   = {2{wdata[7:0]}};
                wd_odd    = {2{wdata[7:0]}};
            end
            SZ_HALF: begin
                bad = addr[0];
                if (!addr[0]) begin
                    mask[idx] = 1'b1;
                end
            end
            SZ_WORD: begin
                bad    = |addr[1:0];
                wd_odd = wdata[31:16];
                if (addr[1:0] == 2'b00) begin
                    mask[idx]               = 1'b1;
                    mask[idx + IDX_W'(1)]   = 1'b1;
                end
            end
            SZ_RSVD: begin
                bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ilv_arbiter.sv
module ilv_arbiter
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_req,
    input  logic                 b_req,
    input  logic [NUM_BANKS-1:0] a_mask,
    input  logic [NUM_BANKS-1:0] b_mask,
    output logic                 a_go,
    output logic                 b_go
);
    arb_state_e state_q;
    arb_state_e state_d;
    logic       clash;

    assign clash = a_req && b_req && (|(a_mask & b_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_BOTH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        a_go    = 1'b0;
        b_go    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ARB_BOTH: begin
                a_go = a_req;
                b_go = b_req && !clash;
                if (clash) begin
                    state_d = ARB_DEFER_B;
                end
            end
            ARB_DEFER_B: begin
                b_go    = b_req;
                state_d = ARB_BOTH;
            end
        endcase
    end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int ROW_W = 6,
    parameter int ROWS  = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [1:0]       be,
    input  logic [ROW_W-1:0] row,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata
);
    logic [15:0] cells_q [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                if (be[0]) begin
                    cells_q[row][7:0] <= wdata[7:0];
                end
                if (be[1]) begin
                    cells_q[row][15:8] <= wdata[15:8];
                end
            end else begin
                rdata <= cells_q[row];
            end
        end
    end
endmodule

// File: rtl/ilv_resp.sv
module ilv_resp
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic                        bad,
    input  logic                        we,
    input  logic [1:0]                  size,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        lane,
    input  logic [NUM_BANKS-1:0][15:0]  bank_rd,
    output logic                        rvalid,
    output logic                        err,
    output logic [31:0]                 rdata
);
    logic             vld_q;
    logic             err_q;
    logic             rd_q;
    acc_size_e        sz_q;
    logic [IDX_W-1:0] idx_q;
    logic             lane_q;
    logic [15:0]      lo;
    logic [15:0]      hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
            rd_q   <= 1'b0;
            sz_q   <= SZ_BYTE;
            idx_q  <= '0;
            lane_q <= 1'b0;
        end else begin
            vld_q <= go;
            err_q <= go && bad;
            rd_q  <= go && !we && !bad;
            if (go) begin
                sz_q   <= acc_size_e'(size);
                idx_q  <= idx;
                lane_q <= lane;
            end
        end
    end

    assign lo = bank_rd[idx_q];
    assign hi = bank_rd[idx_q + IDX_W'(1)];

    always_comb begin
        rdata = '0;
        if (rd_q) begin
            unique case (sz_q)
                SZ_BYTE: rdata = {24'd0, lane_q ? lo[15:8] : lo[7:0]};
                SZ_HALF: rdata = {16'd0, lo};
                SZ_WORD: rdata = {hi, lo};
                SZ_RSVD: rdata = '0;
            endcase
        end
    end

    assign rvalid = vld_q;
    assign err    = err_q;
endmodule

// File: rtl/ilv_dual_mem.sv
module ilv_dual_mem
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROWS      = 64,
    parameter int IDX_W     = $clog2(NUM_BANKS),
    parameter int ROW_W     = $clog2(ROWS),
    parameter int ADDR_W    = ROW_W + IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [1:0]        a_size,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    output logic              a_ready,
    output logic              a_rvalid,
    output logic              a_err,
    output logic [31:0]       a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [1:0]        b_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    output logic              b_ready,
    output logic              b_rvalid,
    output logic              b_err,
    output logic [31:0]       b_rdata
);
    logic                       a_bad, b_bad;
    logic [NUM_BANKS-1:0]       a_mask, b_mask;
    logic [IDX_W-1:0]           a_idx, b_idx;
    logic [ROW_W-1:0]           a_row, b_row;
    logic                       a_lane, b_lane;
    logic [1:0]                 a_be, b_be;
    logic [15:0]                a_wd_even, a_wd_odd, b_wd_even, b_wd_odd;
    logic                       a_go, b_go;
    logic [NUM_BANKS-1:0][15:0] bank_rd;

    ilv_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec_a (
        .size(a_size), .addr(a_addr), .wdata(a_wdata),
        .bad(a_bad), .mask(a_mask), .idx(a_idx), .row(a_row), .lane(a_lane),
        .lane_be(a_be), .wd_even(a_wd_even), .wd_odd(a_wd_odd)
    );

    ilv_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec_b (
        .size(b_size), .addr(b_addr), .wdata(b_wdata),
        .bad(b_bad), .mask(b_mask), .idx(b_idx), .row(b_row), .lane(b_lane),
        .lane_be(b_be), .wd_even(b_wd_even), .wd_odd(b_wd_odd)
    );

    ilv_arbiter #(.NUM_BANKS(NUM_BANKS)) i_arb (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .b_req(b_req),
        .a_mask(a_mask), .b_mask(b_mask),
        .a_go(a_go), .b_go(b_go)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam bit ODD = (k % 2) == 1;
        logic             use_a, use_b, en, we;
        logic [1:0]       be;
        logic [ROW_W-1:0] row;
        logic [15:0]      wd;

        assign use_a = a_go && a_mask[k];
        assign use_b = b_go && b_mask[k];
        assign en    = use_a || use_b;

        always_comb begin
            if (use_a) begin
                we  = a_we;
                be  = a_be;
                row = a_row;
                wd  = ODD ? a_wd_odd : a_wd_even;
            end else begin
                we  = b_we && use_b;
                be  = b_be;
                row = b_row;
                wd  = ODD ? b_wd_odd : b_wd_even;
            end
        end

        ilv_bank #(.ROW_W(ROW_W), .ROWS(ROWS)) i_bank (
            .clk(clk), .en(en), .we(we), .be(be), .row(row),
            .wdata(wd), .rdata(bank_rd[k])
        );
    end

    ilv_resp #(.NUM_BANKS(NUM_BANKS)) i_resp_a (
        .clk(clk), .rst_n(rst_n), .go(a_go), .bad(a_bad), .we(a_we),
        .size(a_size), .idx(a_idx), .lane(a_lane), .bank_rd(bank_rd),
        .rvalid(a_rvalid), .err(a_err), .rdata(a_rdata)
    );

    ilv_resp #(.NUM_BANKS(NUM_BANKS)) i_resp_b (
        .clk(clk), .rst_n(rst_n), .go(b_go), .bad(b_bad), .we(b_we),
        .size(b_size), .idx(b_idx), .lane(b_lane), .bank_rd(bank_rd),
        .rvalid(b_rvalid), .err(b_err), .rdata(b_rdata)
    );

    assign a_ready = a_go;
    assign b_ready = b_go;
endmodule

// File: rtl/ilv_dual_mem_checker.sv
module ilv_dual_mem_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_req,
    input logic              a_ready,
    input logic [1:0]        a_size,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_rvalid,
    input logic              a_err,
    input logic [31:0]       a_rdata,
    input logic              b_req,
    input logic              b_ready,
    input logic              b_rvalid
);
    assert_a_resp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_ready) |=> a_rvalid);

    assert_a_no_spurious_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_req && a_ready) |=> !a_rvalid);

    assert_b_resp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && b_ready) |=> b_rvalid);

    assert_b_wait_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_ready) |=> (!b_req || b_ready));

    assert_a_refused_only_for_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_ready) |-> (b_req && b_ready));

    assert_word_misalign_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_ready && a_size == 2'd2 && a_addr[1:0] != 2'b00) |=> a_err);

    assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rvalid && a_err) |-> (a_rdata == 32'd0));
endmodule

bind ilv_dual_mem ilv_dual_mem_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_ready(a_ready), .a_size(a_size), .a_addr(a_addr),
    .a_rvalid(a_rvalid), .a_err(a_err), .a_rdata(a_rdata),
    .b_req(b_req), .b_ready(b_ready), .b_rvalid(b_rvalid)
);

// File: tb/test_ilv_dual_mem.sv
`timescale 1ns/1ps
module test_ilv_dual_mem;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_req, a_we, b_req, b_we;
    logic [1:0]  a_size, b_size;
    logic [8:0]  a_addr, b_addr;
    logic [31:0] a_wdata, b_wdata;
    logic        a_ready, a_rvalid, a_err, b_ready, b_rvalid, b_err;
    logic [31:0] a_rdata, b_rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] ref_mem [512];

    always #2 clk = ~clk;

    ilv_dual_mem i_ilv_dual_mem (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_ready(a_ready), .a_rvalid(a_rvalid), .a_err(a_err), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_ready(b_ready), .b_rvalid(b_rvalid), .b_err(b_err), .b_rdata(b_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit f_bad(logic [1:0] sz, logic [8:0] ad);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return ad[0];
            2'd2:    return ad[1:0] != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] f_mask(logic [1:0] sz, logic [8:0] ad);
        if (f_bad(sz, ad)) return 4'b0000;
        if (sz == 2'd2) return 4'b0011 << ad[2:1];
        return 4'b0001 << ad[2:1];
    endfunction

    function automatic logic [31:0] f_read(logic [1:0] sz, logic [8:0] ad);
        case (sz)
            2'd0:    return {24'd0, ref_mem[ad]};
            2'd1:    return {16'd0, ref_mem[ad + 9'd1], ref_mem[ad]};
            default: return {ref_mem[ad + 9'd3], ref_mem[ad + 9'd2],
                             ref_mem[ad + 9'd1], ref_mem[ad]};
        endcase
    endfunction

    task automatic f_write(logic [1:0] sz, logic [8:0] ad, logic [31:0] wd);
        ref_mem[ad] = wd[7:0];
        if (sz != 2'd0) ref_mem[ad + 9'd1] = wd[15:8];
        if (sz == 2'd2) begin
            ref_mem[ad + 9'd2] = wd[23:16];
            ref_mem[ad + 9'd3] = wd[31:24];
        end
    endtask

    function automatic string f_tag(logic [1:0] sz, bit bad);
        if (bad) return "R7 err rdata";
        if (sz == 2'd2) return "R1 word rdata";
        return "R8 sub-word rdata";
    endfunction

    task automatic run_pair(bit ae, bit aw, logic [1:0] asz, logic [8:0] aad, logic [31:0] awd,
                            bit be_, bit bw, logic [1:0] bsz, logic [8:0] bad_, logic [31:0] bwd);
        bit          a_bad_x, b_bad_x, clash;
        logic [31:0] exp_a, exp_b;
        a_bad_x = f_bad(asz, aad);
        b_bad_x = f_bad(bsz, bad_);
        clash   = ae && be_ && ((f_mask(asz, aad) & f_mask(bsz, bad_)) != 4'b0000);
        exp_a = 32'd0;
        exp_b = 32'd0;
        if (ae && !a_bad_x) begin
            if (aw) f_write(asz, aad, awd);
            else    exp_a = f_read(asz, aad);
        end
        if (be_ && !b_bad_x) begin
            if (bw) f_write(bsz, bad_, bwd);
            else    exp_b = f_read(bsz, bad_);
        end
        @(negedge clk);
        a_req = ae;  a_we = aw; a_size = asz; a_addr = aad;  a_wdata = awd;
        b_req = be_; b_we = bw; b_size = bsz; b_addr = bad_; b_wdata = bwd;
        #1;
        chk("R3 a_ready", {31'd0, a_ready}, {31'd0, ae});
        chk(clash ? "R4 b_ready stalled (R1 map)" : "R3 b_ready",
            {31'd0, b_ready}, {31'd0, be_ && !clash});
        @(negedge clk);
        chk("R6 a_rvalid", {31'd0, a_rvalid}, {31'd0, ae});
        if (ae) begin
            chk("R7 a_err", {31'd0, a_err}, {31'd0, a_bad_x});
            chk(f_tag(asz, a_bad_x), a_rdata, exp_a);
        end
        chk("R6 b_rvalid", {31'd0, b_rvalid}, {31'd0, be_ && !clash});
        if (be_ && !clash) begin
            chk("R7 b_err", {31'd0, b_err}, {31'd0, b_bad_x});
            chk(f_tag(bsz, b_bad_x), b_rdata, exp_b);
        end
        a_req = 1'b0;
        if (!clash) b_req = 1'b0;
        if (clash) begin
            #1;
            chk("R4 b_ready deferred", {31'd0, b_ready}, 32'd1);
            @(negedge clk);
            b_req = 1'b0;
            chk("R4 b_rvalid deferred", {31'd0, b_rvalid}, 32'd1);
            chk("R4 b_rdata after A", b_rdata, exp_b);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog expired act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed_dummy;
        logic [31:0] exp_v;
        rst_n = 1'b0;
        a_req = 1'b0; a_we = 1'b0; a_size = 2'd0; a_addr = '0; a_wdata = '0;
        b_req = 1'b0; b_we = 1'b0; b_size = 2'd0; b_addr = '0; b_wdata = '0;
        seed_dummy = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        chk("R2 a_rvalid in reset", {31'd0, a_rvalid}, 32'd0);
        chk("R2 b_rvalid in reset", {31'd0, b_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 a_rvalid after reset", {31'd0, a_rvalid}, 32'd0);
        chk("R2 b_rvalid after reset", {31'd0, b_rvalid}, 32'd0);

        // fill all memory: A on banks 0/1, B on banks 2/3 in the same cycle (R3)
        for (int i = 0; i < 64; i++) begin
            run_pair(1'b1, 1'b1, 2'd2, 9'(i * 8), (32'(i) * 32'h0103_0507) ^ 32'hA5A5_0000,
                     1'b1, 1'b1, 2'd2, 9'(i * 8 + 4), (32'(i) * 32'h0709_0B0D) ^ 32'h5A5A_0000);
        end

        // R1: word lane order, disjoint banks
        run_pair(1'b1, 1'b0, 2'd2, 9'h010, '0, 1'b1, 1'b0, 2'd2, 9'h01C, '0);
        // R4: A writes word, B reads same word in the clash cycle
        run_pair(1'b1, 1'b1, 2'd2, 9'h020, 32'hDEAD_BEEF, 1'b1, 1'b0, 2'd2, 9'h020, '0);
        // R4: word pair overlap through a halfword in bank 1
        run_pair(1'b1, 1'b0, 2'd2, 9'h028, '0, 1'b1, 1'b1, 2'd1, 9'h02A, 32'h0000_1234);
        // R8: odd byte write then halfword read, disjoint banks
        run_pair(1'b1, 1'b1, 2'd0, 9'h031, 32'h0000_00C3, 1'b1, 1'b0, 2'd0, 9'h036, '0);
        run_pair(1'b1, 1'b0, 2'd1, 9'h030, '0, 1'b1, 1'b0, 2'd1, 9'h032, '0);
        // R7: misaligned word write must not modify memory nor clash
        run_pair(1'b1, 1'b1, 2'd2, 9'h042, 32'h1111_2222, 1'b1, 1'b0, 2'd2, 9'h040, '0);
        run_pair(1'b1, 1'b0, 2'd2, 9'h040, '0, 1'b1, 1'b1, 2'd3, 9'h040, 32'h3333_4444);
        run_pair(1'b1, 1'b1, 2'd1, 9'h045, 32'h5555, 1'b1, 1'b0, 2'd2, 9'h044, '0);

        // R5: A refused while deferred B is served
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b0; a_size = 2'd2; a_addr = 9'h000;
        b_req = 1'b1; b_we = 1'b0; b_size = 2'd1; b_addr = 9'h002;
        #1;
        chk("R4 clash b_ready low", {31'd0, b_ready}, 32'd0);
        @(negedge clk);
        chk("R6 a_rdata word", a_rdata, f_read(2'd2, 9'h000));
        a_size = 2'd0; a_addr = 9'h005;
        #1;
        chk("R5 a_ready low during deferral", {31'd0, a_ready}, 32'd0);
        chk("R5 b_ready high during deferral", {31'd0, b_ready}, 32'd1);
        @(negedge clk);
        chk("R5 b_rdata deferred", b_rdata, f_read(2'd1, 9'h002));
        chk("R5 a_rvalid low after refusal", {31'd0, a_rvalid}, 32'd0);
        b_req = 1'b0;
        #1;
        chk("R5 a_ready restored", {31'd0, a_ready}, 32'd1);
        @(negedge clk);
        exp_v = f_read(2'd0, 9'h005);
        chk("R5 a_rdata after wait", a_rdata, exp_v);
        a_req = 1'b0;

        // constrained random pairs
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  asz, bsz;
            logic [8:0]  aad, bad_;
            bit          aw, bw, ae, be_;
            asz  = 2'($urandom_range(0, 3) == 3 ? ($urandom_range(0, 7) == 0 ? 3 : 2) : $urandom_range(0, 2));
            bsz  = 2'($urandom_range(0, 2));
            aad  = ($urandom_range(0, 1) == 0) ? 9'($urandom_range(0, 15)) : 9'($urandom_range(0, 511));
            bad_ = ($urandom_range(0, 1) == 0) ? 9'($urandom_range(0, 15)) : 9'($urandom_range(0, 511));
            if ($urandom_range(0, 7) != 0) begin
                if (asz == 2'd2) aad[1:0] = 2'b00;
                if (asz == 2'd1) aad[0]   = 1'b0;
            end
            if ($urandom_range(0, 7) != 0) begin
                if (bsz == 2'd2) bad_[1:0] = 2'b00;
                if (bsz == 2'd1) bad_[0]   = 1'b0;
            end
            aw  = $urandom_range(0, 1) == 1;
            bw  = $urandom_range(0, 1) == 1;
            ae  = $urandom_range(0, 5) != 0;
            be_ = $urandom_range(0, 5) != 0;
            run_pair(ae, aw, asz, aad, $urandom(), be_, bw, bsz, bad_, $urandom());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule